// File: doc/BRIEF.md
# Prescaled Reference-Match Timer

This block is a general-purpose up-counter with a divided clock. Software programs it through a small synchronous register port that is addressed by byte offset. A control word sets the divide ratio, the clock source, the restart behaviour and the interrupt enable. The counter advances by one on each divided tick. When it lands on the programmed reference value, a sticky match flag is raised. On the following tick the counter returns to zero.

The interrupt line is the match flag gated by its enable bit. Software clears the flag by writing a one to that bit position.

A capture register is also provided. It is plain storage: it holds whatever software writes to it, and nothing in the block ever loads it. When a write turns the enable bit from 1 to 0, the control word and the reference value are both wiped to zero.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `rdata` is 0.
- R2: The register offsets are as follows.
  - Control at 0x00: bit 0 enable, bits 2:1 clock source, bit 3 restart, bit 4 interrupt enable, bits 15:8 prescale.
  - Reference at 0x04.
  - Capture at 0x08, plain storage.
  - Count at 0x0C.
  - Status at 0x11: bit 1 is the match flag and all other bits read 0.
  
  Reads of any other offset return 0. `rdata` is updated in the cycle after `rd_en` and holds until the next read.
- R3: The count changes on a tick only when enable=1, restart=1 and the clock source is 1 or 2. Clock sources 0 and 3 keep the counter frozen.
- R4: The counter advances once every P+1 clock cycles with clock source 1, and once every 16*(P+1) clock cycles with clock source 2, where P is control bits 15:8.
- R5: The tick that makes the count equal to the reference sets the match flag. The next tick returns the count to 0, so the count period is reference+1 ticks.
- R6: `irq` is 1 exactly when the interrupt enable bit and the match flag are both 1.
- R7: A status write clears each flag bit written as 1 and leaves the other bits unchanged.
- R8: A control write with bit 0 at 0, while the stored enable is 1, sets both the control and reference registers to 0. A control write with the enable already 0 stores its data as written.
- R9: A count write loads the counter and restarts the divider phase. The next increment therefore comes a full divide period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Match interrupt request |

## Verification
The assertions check the following on every cycle:
- the counter stays frozen while it is stopped and not being written;
- the counter returns to zero after a match tick;
- the match flag rises only on a tick that lands on the reference;
- a write-one clear takes effect;
- a disabling control write wipes the control and reference registers;
- the interrupt never drops without a write.

The exact divide ratio for each prescale value and clock source can only be shown by the bench. The same holds for the one-cycle read latency, the read-back of each offset, and the phase restart after a count load. The bench sweeps every prescale value from 0 to 7 under both active clock sources and times the counter arithmetically.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned PSC_W     = 8;
  localparam int unsigned SLOW_LOG2 = 4;

  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_REF  = 'h04;
  localparam int unsigned OFS_CAP  = 'h08;
  localparam int unsigned OFS_CNT  = 'h0C;
  localparam int unsigned OFS_STAT = 'h11;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [1:0]       edge_sel;
    logic             out_mode;
    logic             irq_en;
    logic             restart;
    logic [1:0]       src;
    logic             enable;
  } ctrl_t;

  localparam logic [1:0] SRC_FAST = 2'd1;
  localparam logic [1:0] SRC_SLOW = 2'd2;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned PSC_W     = 8,
  parameter int unsigned SLOW_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic [PSC_W-1:0] psc,
  input  logic             phase_clr,
  output logic             tick
);
  localparam int unsigned PH_W = PSC_W + SLOW_LOG2;

  logic [PH_W-1:0] phase_q, phase_d, limit;

  // Terminal phase: P for the fast source, 16*(P+1)-1 for the slow one.
  always_comb begin
    if (slow) limit = {psc, {SLOW_LOG2{1'b1}}};
    else      limit = {{SLOW_LOG2{1'b0}}, psc};
  end

  assign tick = run && (phase_q >= limit);

  always_comb begin
    if (!run || phase_clr)    phase_d = '0;
    else if (phase_q >= limit) phase_d = '0;
    else                      phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)                     cnt_d = load_val;
    else if (tick && cnt == ref_val) cnt_d = '0;
    else if (tick)                cnt_d = cnt + 1'b1;
  end

  assign hit = tick && !load && (cnt_d == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  ref_val,
  output logic              cnt_load,
  output logic              flag,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic sel_ctrl, sel_ref, sel_cap, sel_cnt, sel_stat;
  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_ref  = (addr == ADDR_W'(OFS_REF));
  assign sel_cap  = (addr == ADDR_W'(OFS_CAP));
  assign sel_cnt  = (addr == ADDR_W'(OFS_CNT));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));

  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] ref_d, cap_q, cap_d;
  logic             flag_d;
  logic [REG_W-1:0] rdata_d, rd_mux;

  assign cnt_load = wr_en && sel_cnt;

  always_comb begin
    ctrl_d = ctrl;
    ref_d  = ref_val;
    cap_d  = cap_q;
    flag_d = flag;
    if (wr_en && sel_ctrl) begin
      if (ctrl.enable && !wdata[0]) begin
        ctrl_d = '0;
        ref_d  = '0;
      end else begin
        ctrl_d = ctrl_t'(wdata);
      end
    end
    if (wr_en && sel_ref) ref_d = wdata[CNT_W-1:0];
    if (wr_en && sel_cap) cap_d = wdata[CNT_W-1:0];
    if (wr_en && sel_stat && wdata[1]) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)      rd_mux = REG_W'(ctrl);
    else if (sel_ref)  rd_mux = REG_W'(ref_val);
    else if (sel_cap)  rd_mux = REG_W'(cap_q);
    else if (sel_cnt)  rd_mux = REG_W'(cnt);
    else if (sel_stat) rd_mux = REG_W'({flag, 1'b0});
    rdata_d = rd_en ? rd_mux : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      ref_val <= '0;
      cap_q   <= '0;
      flag    <= 1'b0;
      rdata   <= '0;
    end else begin
      ctrl    <= ctrl_d;
      ref_val <= ref_d;
      cap_q   <= cap_d;
      flag    <= flag_d;
      rdata   <= rdata_d;
    end
  end

  assign irq = ctrl.irq_en && flag;
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              irq
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] ref_val, cnt;
  logic             cnt_load, flag, hit, tick, run;

  assign run = ctrl.enable && ctrl.restart &&
               (ctrl.src == SRC_FAST || ctrl.src == SRC_SLOW);

  gpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .hit(hit), .ctrl(ctrl), .ref_val(ref_val),
    .cnt_load(cnt_load), .flag(flag), .rdata(rdata), .irq(irq)
  );

  gpt_prescaler #(.PSC_W(PSC_W), .SLOW_LOG2(SLOW_LOG2)) u_psc (
    .clk(clk), .rst_n(rst_n_s), .run(run), .slow(ctrl.src == SRC_SLOW),
    .psc(ctrl.psc), .phase_clr(cnt_load), .tick(tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .load(cnt_load),
    .load_val(wdata[CNT_W-1:0]), .ref_val(ref_val), .cnt(cnt), .hit(hit)
  );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic              irq,
  input logic              tick,
  input logic              run,
  input logic              hit,
  input logic              flag,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ref_val,
  input ctrl_t             ctrl
);
  logic ld, stat_wr, ctrl_wr;
  assign ld      = wr_en && addr == ADDR_W'(OFS_CNT);
  assign stat_wr = wr_en && addr == ADDR_W'(OFS_STAT);
  assign ctrl_wr = wr_en && addr == ADDR_W'(OFS_CTRL);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt == ref_val) |=> cnt == '0);

  p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(tick) && cnt == $past(ref_val)));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (irq || $past(wr_en)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[1] && !hit) |=> !flag);

  p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl.enable && !wdata[0]) |=> (ctrl == '0 && ref_val == '0));
endmodule

bind gpt_timer gpt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .tick(tick), .run(run), .hit(hit), .flag(flag), .cnt(cnt),
  .ref_val(ref_val), .ctrl(ctrl)
);

// File: tb/gpt_timer_test.sv
module gpt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  gpt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input int psc, input int src,
                                      input bit ie, input bit rs, input bit en);
    return 16'((psc << 8) | (int'(ie) << 4) | (int'(rs) << 3) | (src << 1) | int'(en));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd(5'h00, v); chk("R1 ctrl", v, 16'h0);
    rd(5'h04, v); chk("R1 ref", v, 16'h0);
    rd(5'h0C, v); chk("R1 cnt", v, 16'h0);
    rd(5'h11, v); chk("R1 stat", v, 16'h0);

    // R2 map and read-back
    wr(5'h08, 16'hBEEF); rd(5'h08, v); chk("R2 capture", v, 16'hBEEF);
    wr(5'h04, 16'h1234); rd(5'h04, v); chk("R2 ref", v, 16'h1234);
    idle(3); chk("R2 rdata holds", rdata, 16'h1234);
    for (int a = 0; a < 32; a++) begin
      if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h0C && a != 'h11) begin
        rd(5'(a), v); chk("R2 unmapped", v, 16'h0);
      end
    end

    // R4 divide sweep over prescale 0..7 and both active sources
    for (int s = 1; s <= 2; s++) begin
      for (int p = 0; p < 8; p++) begin
        int dv;
        dv = (s == 2) ? (p + 1) * 16 : (p + 1);
        wr(5'h04, 16'hFFFF);
        wr(5'h0C, 16'h0000);
        wr(5'h00, ctl(p, s, 0, 1, 1));
        idle(3 * dv - 1);
        rd(5'h0C, v); chk("R4 before third tick", v, 16'd2);
        rd(5'h0C, v); chk("R4 at third tick", v, 16'd3);
        wr(5'h00, 16'h0000);
      end
    end

    // R3 inactive sources and restart=0 keep the count frozen
    for (int s = 0; s <= 3; s += 3) begin
      wr(5'h0C, 16'h0005);
      wr(5'h00, ctl(0, s, 0, 1, 1));
      idle(20);
      rd(5'h0C, v); chk("R3 src frozen", v, 16'h0005);
      wr(5'h00, 16'h0000);
    end
    wr(5'h0C, 16'h0007);
    wr(5'h00, ctl(0, 1, 0, 0, 1));
    idle(20);
    rd(5'h0C, v); chk("R3 restart off frozen", v, 16'h0007);
    wr(5'h00, 16'h0000);

    // R5 match, wrap and R6 interrupt
    wr(5'h04, 16'd3);
    wr(5'h0C, 16'd0);
    wr(5'h00, ctl(0, 1, 1, 1, 1));
    idle(2);
    rd(5'h11, v); chk("R5 flag not yet", v, 16'h0);
    chk("R6 irq after match", 16'(irq), 16'h1);
    rd(5'h0C, v); chk("R5 count at ref", v, 16'd3);
    rd(5'h0C, v); chk("R5 wrap to zero", v, 16'd0);
    wr(5'h00, ctl(0, 1, 1, 0, 1));
    rd(5'h0C, v); chk("R3 stopped count", v, 16'd2);
    idle(10);
    rd(5'h0C, v); chk("R3 still stopped", v, 16'd2);
    wr(5'h00, ctl(0, 1, 0, 0, 1));
    chk("R6 masked", 16'(irq), 16'h0);
    wr(5'h00, ctl(0, 1, 1, 0, 1));
    chk("R6 unmasked", 16'(irq), 16'h1);

    // R7 write-one clear
    wr(5'h11, 16'h0001);
    chk("R7 other bit no effect", 16'(irq), 16'h1);
    rd(5'h11, v); chk("R7 flag kept", v, 16'h0002);
    wr(5'h11, 16'h0002);
    chk("R7 irq cleared", 16'(irq), 16'h0);
    rd(5'h11, v); chk("R7 flag cleared", v, 16'h0000);

    // R8 disable wipes control and reference
    wr(5'h00, 16'h1209);
    rd(5'h00, v); chk("R8 ctrl stored", v, 16'h1209);
    wr(5'h04, 16'h0ABC);
    wr(5'h00, 16'h00F0);
    rd(5'h00, v); chk("R8 ctrl wiped", v, 16'h0);
    rd(5'h04, v); chk("R8 ref wiped", v, 16'h0);
    wr(5'h04, 16'h0055);
    wr(5'h00, 16'h0030);
    rd(5'h00, v); chk("R8 ctrl kept when idle", v, 16'h0030);
    rd(5'h04, v); chk("R8 ref kept when idle", v, 16'h0055);

    // R9 count load restarts the divider phase (divide by 4)
    wr(5'h04, 16'hFFFF);
    wr(5'h0C, 16'h0000);
    wr(5'h00, ctl(3, 1, 0, 1, 1));
    idle(6);
    wr(5'h0C, 16'h0010);
    idle(3);
    rd(5'h0C, v); chk("R9 loaded value", v, 16'h0010);
    rd(5'h0C, v); chk("R9 first step after load", v, 16'h0011);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule